// File: doc/BRIEF.md
# Controller Command and Status Register

This unit holds the main command/status word of a DMA network controller. The host writes it to start the controller, stop it, or ask for an initialization pass. The unit turns those writes into level controls, including receive-enable and transmit-enable indications. It also sends a one-cycle request to the buffer-management engine whenever an initialization pass is asked for.

The buffer manager reports back with two pulses. One says the initialization block has been read. The other says a transmit descriptor has been fetched. The first sets a done flag. The second retires a pending transmit-demand request.

Interrupt event pulses latch into sticky flags that the host clears by writing one. The flags that are not masked are ORed into a read-only summary bit. That summary drives an active-low interrupt pin when interrupts are enabled.

Top module: `csr_cmd_status`

## Requirements
- R1: Hard or soft reset sets STOP (bit 2) and clears STRT, TDMD, TXON, RXON, IENA, IDON and all event flags, with intN high. A soft reset also clears INIT (bit 0). A hard reset leaves INIT unchanged.
- R2: Writing 1 to bit 0 sets INIT and clears STOP. It also raises initReq for exactly the one cycle after the write. INIT clears when initDone arrives.
- R3: Writing 1 to bit 1 sets STRT and clears STOP. Writing 0 to bits 0 to 3 changes nothing.
- R4: A write with bit 2 set leaves STOP set and STRT clear, and raises no initReq, even when bits 0 and 1 are set in the same write.
- R5: While STOP is set, STRT, TDMD, RXON and TXON are clear. Setting STOP also clears IENA, IDON and all event flags, even against a same-cycle event.
- R6: Once STRT is set, RXON (bit 5) sets when rxDisable is 0 and TXON (bit 4) sets when txDisable is 0. A disabled direction stays clear. Both bits are read-only.
- R7: When STRT and INIT are written together, RXON and TXON stay clear until initDone. They set on the same edge at which INIT clears.
- R8: Writing 1 to bit 3 sets TDMD only while TXON is set. TDMD clears on descFetched, and TDMD is never set while TXON is clear.
- R9: IDON (bit 8) sets on initDone and is cleared by writing 1 to bit 8. An initDone in the same cycle as that write leaves IDON set.
- R10: evtPulse[k] sets event flag bit 9+k, which is cleared by writing 1 to that bit. A pulse in the same cycle as the clear wins.
- R11: INTR (bit 7) is 1 exactly when a flag is set whose mask bit is 0. evtMask[0] masks IDON and evtMask[k+1] masks event k. Writes to bit 7 have no effect.
- R12: IENA (bit 6) takes the written value on each write without STOP. intN is low exactly when IENA and INTR are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| hardRst | input | 1 | Synchronous hard reset, active high |
| softRst | input | 1 | Synchronous soft reset, active high |
| wrEn | input | 1 | Host write strobe |
| wrData | input | 16 | Host write data |
| initDone | input | 1 | Pulse: initialization block has been read |
| descFetched | input | 1 | Pulse: transmit descriptor has been fetched |
| evtPulse | input | NUM_SRC (7) | Interrupt event pulses |
| evtMask | input | NUM_SRC+1 (8) | Mask bits, 1 = masked |
| rxDisable | input | 1 | Keep the receive enable off |
| txDisable | input | 1 | Keep the transmit enable off |
| csrRead | output | 16 | Current register value |
| initReq | output | 1 | One-cycle initialization request |
| intN | output | 1 | Interrupt output, active low |

## Verification
Start alone is compared with start plus init. This shows whether the receive and transmit enables are correctly held back until the done pulse arrives. Writes that combine STOP with START and INIT show the override. Writes of zero show that set-only bits ignore zero.

Event pulses are driven with mixed mask patterns, and with IENA both off and on. This separates the summary flag from the pin gating. Clears are also driven in the same cycle as the event or done pulse they clear, which exposes any loss of that event. Hard and soft reset are each applied with an init pending, which tells apart their different treatment of INIT.

// File: rtl/csr_pkg.sv
package csr_pkg;
  localparam int CSR_W    = 16;
  localparam int B_INIT   = 0;
  localparam int B_STRT   = 1;
  localparam int B_STOP   = 2;
  localparam int B_TDMD   = 3;
  localparam int B_TXON   = 4;
  localparam int B_RXON   = 5;
  localparam int B_IENA   = 6;
  localparam int B_INTR   = 7;
  localparam int FLAG_LO  = 8;   // IDON, then the event flags above it

  // Strobes from the command control to the flag datapath
  typedef struct packed {
    logic             clrAll;   // reset or STOP
    logic [CSR_W-1:0] w1c;      // write-one-to-clear bits (zero when no write)
  } flagCtl_t;
endpackage

// File: rtl/csr_cmd_ctrl.sv
module csr_cmd_ctrl
  import csr_pkg::*;
(
  input  logic             clk,
  input  logic             hardRst,
  input  logic             softRst,
  input  logic             wrEn,
  input  logic [CSR_W-1:0] wrData,
  input  logic             initDone,
  input  logic             descFetched,
  input  logic             rxDisable,
  input  logic             txDisable,
  output logic             initQ,
  output logic             strtQ,
  output logic             stopQ,
  output logic             tdmdQ,
  output logic             txonQ,
  output logic             rxonQ,
  output logic             ienaQ,
  output logic             initReq,
  output flagCtl_t         flagCtl
);
  logic [CSR_W-1:0] wrBits;
  logic anyRst, stopHit;
  logic initN, strtN, stopN, tdmdN, txonN, rxonN, ienaN, reqN;

  always_comb begin
    wrBits  = wrEn ? wrData : '0;
    anyRst  = hardRst | softRst;
    stopHit = wrBits[B_STOP];
    flagCtl.clrAll = anyRst | stopHit;
    flagCtl.w1c    = wrBits;
  end

  always_comb begin
    initN = initQ; strtN = strtQ; stopN = stopQ; tdmdN = tdmdQ;
    txonN = txonQ; rxonN = rxonQ; ienaN = ienaQ; reqN = 1'b0;
    if (anyRst || stopHit) begin
      stopN = 1'b1;
      strtN = 1'b0;
      tdmdN = 1'b0;
      txonN = 1'b0;
      rxonN = 1'b0;
      ienaN = 1'b0;
      if (softRst) initN = 1'b0;
    end else begin
      if (wrBits[B_INIT]) begin
        initN = 1'b1;
        stopN = 1'b0;
        reqN  = 1'b1;
      end else if (initDone) begin
        initN = 1'b0;
      end
      if (wrBits[B_STRT]) begin
        strtN = 1'b1;
        stopN = 1'b0;
      end
      if (wrEn) ienaN = wrData[B_IENA];
      // enables wait for the init pass when one is pending
      rxonN = rxonQ | (strtN & ~initN & ~rxDisable);
      txonN = txonQ | (strtN & ~initN & ~txDisable);
      tdmdN = txonN & (wrBits[B_TDMD] | (tdmdQ & ~descFetched));
    end
  end

  always_ff @(posedge clk) begin
    initQ   <= initN;
    strtQ   <= strtN;
    stopQ   <= stopN;
    tdmdQ   <= tdmdN;
    txonQ   <= txonN;
    rxonQ   <= rxonN;
    ienaQ   <= ienaN;
    initReq <= reqN;
  end

  a_r4_stop_wins: assert property (@(posedge clk) disable iff (hardRst)
    (wrEn && wrData[B_STOP]) |=> (stopQ && !strtQ && !initReq));

  a_r5_stop_quiet: assert property (@(posedge clk) disable iff (hardRst)
    stopQ |-> (!strtQ && !rxonQ && !txonQ && !tdmdQ));

  a_r7_enable_after_init: assert property (@(posedge clk) disable iff (hardRst)
    ($rose(rxonQ) || $rose(txonQ)) |-> (strtQ && !initQ));

  a_r8_tdmd_needs_tx: assert property (@(posedge clk) disable iff (hardRst)
    tdmdQ |-> txonQ);

  a_r2_req_source: assert property (@(posedge clk) disable iff (hardRst)
    initReq |-> $past(wrEn && wrData[B_INIT] && !wrData[B_STOP] && !softRst));
endmodule

// File: rtl/csr_event_flags.sv
module csr_event_flags
  import csr_pkg::*;
#(
  parameter int NUM_SRC = 7,
  localparam int FLAG_W = NUM_SRC + 1
) (
  input  logic              clk,
  input  logic              hardRst,
  input  flagCtl_t          flagCtl,
  input  logic [FLAG_W-1:0] evtIn,
  input  logic [FLAG_W-1:0] maskIn,
  output logic [FLAG_W-1:0] flagQ,
  output logic              intrOut
);
  for (genvar i = 0; i < FLAG_W; i++) begin : g_flag
    logic clrBit;
    assign clrBit = flagCtl.w1c[FLAG_LO + i];

    // a same-cycle event beats the write-one clear
    always_ff @(posedge clk) begin
      if (flagCtl.clrAll) flagQ[i] <= 1'b0;
      else                flagQ[i] <= evtIn[i] | (flagQ[i] & ~clrBit);
    end

    a_r10_event_kept: assert property (@(posedge clk) disable iff (hardRst)
      (!flagCtl.clrAll && evtIn[i]) |=> flagQ[i]);

    a_r10_clear_works: assert property (@(posedge clk) disable iff (hardRst)
      (!flagCtl.clrAll && !evtIn[i] && clrBit) |=> !flagQ[i]);
  end

  assign intrOut = |(flagQ & ~maskIn);

  a_r5_stop_flushes: assert property (@(posedge clk) disable iff (hardRst)
    flagCtl.clrAll |=> (flagQ == '0));
endmodule

// File: rtl/csr_cmd_status.sv
module csr_cmd_status
  import csr_pkg::*;
#(
  parameter int NUM_SRC = 7,
  localparam int FLAG_W = NUM_SRC + 1
) (
  input  logic               clk,
  input  logic               hardRst,
  input  logic               softRst,
  input  logic               wrEn,
  input  logic [CSR_W-1:0]   wrData,
  input  logic               initDone,
  input  logic               descFetched,
  input  logic [NUM_SRC-1:0] evtPulse,
  input  logic [FLAG_W-1:0]  evtMask,
  input  logic               rxDisable,
  input  logic               txDisable,
  output logic [CSR_W-1:0]   csrRead,
  output logic               initReq,
  output logic               intN
);
  flagCtl_t flagCtl;
  logic initQ, strtQ, stopQ, tdmdQ, txonQ, rxonQ, ienaQ, intr;
  logic [FLAG_W-1:0] flagQ;

  csr_cmd_ctrl i_ctrl (
    .clk(clk), .hardRst(hardRst), .softRst(softRst),
    .wrEn(wrEn), .wrData(wrData), .initDone(initDone),
    .descFetched(descFetched), .rxDisable(rxDisable), .txDisable(txDisable),
    .initQ(initQ), .strtQ(strtQ), .stopQ(stopQ), .tdmdQ(tdmdQ),
    .txonQ(txonQ), .rxonQ(rxonQ), .ienaQ(ienaQ),
    .initReq(initReq), .flagCtl(flagCtl)
  );

  csr_event_flags #(.NUM_SRC(NUM_SRC)) i_flags (
    .clk(clk), .hardRst(hardRst), .flagCtl(flagCtl),
    .evtIn({evtPulse, initDone}), .maskIn(evtMask),
    .flagQ(flagQ), .intrOut(intr)
  );

  always_comb begin
    csrRead = '0;
    csrRead[B_INIT] = initQ;
    csrRead[B_STRT] = strtQ;
    csrRead[B_STOP] = stopQ;
    csrRead[B_TDMD] = tdmdQ;
    csrRead[B_TXON] = txonQ;
    csrRead[B_RXON] = rxonQ;
    csrRead[B_IENA] = ienaQ;
    csrRead[B_INTR] = intr;
    csrRead[FLAG_LO +: FLAG_W] = flagQ;
  end

  assign intN = ~(ienaQ & intr);

  a_r12_pin_gated: assert property (@(posedge clk) disable iff (hardRst)
    !intN |-> (csrRead[B_IENA] && csrRead[B_INTR]));
endmodule

// File: tb/test_csr_cmd_status.sv
module test_csr_cmd_status;
  logic        clk = 1'b0;
  logic        hardRst = 1'b1, softRst = 1'b1;
  logic        wrEn = 1'b0;
  logic [15:0] wrData = '0;
  logic        initDone = 1'b0, descFetched = 1'b0;
  logic [6:0]  evtPulse = '0;
  logic [7:0]  evtMask = 8'hFF;
  logic        rxDisable = 1'b0, txDisable = 1'b0;
  logic [15:0] csrRead;
  logic        initReq, intN;
  int errors = 0, checks = 0;
  bit done = 0;

  always #5 clk = ~clk;

  csr_cmd_status i_csr_cmd_status (
    .clk(clk), .hardRst(hardRst), .softRst(softRst), .wrEn(wrEn),
    .wrData(wrData), .initDone(initDone), .descFetched(descFetched),
    .evtPulse(evtPulse), .evtMask(evtMask), .rxDisable(rxDisable),
    .txDisable(txDisable), .csrRead(csrRead), .initReq(initReq), .intN(intN));

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(logic [15:0] d);
    wrEn = 1'b1; wrData = d;
    @(negedge clk);
    wrEn = 1'b0; wrData = '0;
  endtask

  task automatic t_reset;
    chk("R1 reset value", csrRead, 16'h0004);
    chk("R1 intN high", {15'd0, intN}, 16'd1);
    chk("R1 no initReq", {15'd0, initReq}, 16'd0);
  endtask

  task automatic t_zero_write;
    wr(16'h0000);
    chk("R3 zero write ignored", csrRead, 16'h0004);
  endtask

  task automatic t_start_alone;
    wr(16'h0002);
    chk("R3 R6 start enables rx tx", csrRead, 16'h0032);
  endtask

  task automatic t_tdmd;
    wr(16'h0008);
    chk("R8 tdmd set", csrRead, 16'h003A);
    descFetched = 1'b1; @(negedge clk); descFetched = 1'b0;
    chk("R8 tdmd cleared by fetch", csrRead, 16'h0032);
  endtask

  task automatic t_stop;
    wr(16'h0044);
    chk("R5 stop clears all", csrRead, 16'h0004);
    wr(16'h0008);
    chk("R8 tdmd refused when stopped", csrRead, 16'h0004);
    txDisable = 1'b1;
    wr(16'h0002);
    chk("R6 tx disabled", csrRead, 16'h0022);
    wr(16'h0008);
    chk("R8 tdmd refused without txon", csrRead, 16'h0022);
    txDisable = 1'b0;
  endtask

  task automatic t_stop_wins;
    wr(16'h0007);
    chk("R4 stop overrides", csrRead, 16'h0004);
    chk("R4 no initReq", {15'd0, initReq}, 16'd0);
  endtask

  task automatic t_start_init;
    wr(16'h0003);
    chk("R2 initReq pulse", {15'd0, initReq}, 16'd1);
    chk("R7 enables held", csrRead, 16'h0003);
    cyc(1);
    chk("R2 initReq single cycle", {15'd0, initReq}, 16'd0);
    cyc(2);
    chk("R7 still held", csrRead, 16'h0003);
    initDone = 1'b1; @(negedge clk); initDone = 1'b0;
    chk("R7 R9 enables after done", csrRead, 16'h0132);
  endtask

  task automatic t_idon;
    wr(16'h0100);
    chk("R9 idon w1c", csrRead, 16'h0032);
    initDone = 1'b1; wrEn = 1'b1; wrData = 16'h0100;
    @(negedge clk);
    initDone = 1'b0; wrEn = 1'b0; wrData = '0;
    chk("R9 done beats clear", csrRead, 16'h0132);
    wr(16'h0100);
    chk("R9 idon cleared again", csrRead, 16'h0032);
  endtask

  task automatic t_events;
    evtPulse = 7'b0000101; @(negedge clk); evtPulse = '0;
    chk("R10 flags latched", csrRead, 16'h0A32);
    chk("R11 masked no irq", {15'd0, intN}, 16'd1);
    evtMask = 8'b1111_0111;
    #1;
    chk("R11 intr from unmasked", csrRead, 16'h0AB2);
    chk("R12 pin off without iena", {15'd0, intN}, 16'd1);
    wr(16'h0040);
    chk("R12 iena set", csrRead, 16'h0AF2);
    chk("R12 pin low", {15'd0, intN}, 16'd0);
    wr(16'h00C0);
    chk("R11 intr write ignored", csrRead, 16'h0AF2);
    evtPulse = 7'b0000100; wrEn = 1'b1; wrData = 16'h0840;
    @(negedge clk);
    evtPulse = '0; wrEn = 1'b0; wrData = '0;
    chk("R10 event beats clear", csrRead, 16'h0AF2);
    wr(16'h0840);
    chk("R10 R11 clear drops intr", csrRead, 16'h0272);
    chk("R12 pin released", {15'd0, intN}, 16'd1);
    wr(16'h0000);
    chk("R12 iena follows write", csrRead, 16'h0232);
  endtask

  task automatic t_stop_flags;
    evtPulse = 7'b1000000; wrEn = 1'b1; wrData = 16'h0004;
    @(negedge clk);
    evtPulse = '0; wrEn = 1'b0; wrData = '0;
    chk("R5 stop clears flags", csrRead, 16'h0004);
  endtask

  task automatic t_resets;
    wr(16'h0001);
    chk("R2 init clears stop", csrRead, 16'h0001);
    hardRst = 1'b1; @(negedge clk); hardRst = 1'b0;
    chk("R1 hard reset keeps init", csrRead, 16'h0005);
    softRst = 1'b1; @(negedge clk); softRst = 1'b0;
    chk("R1 soft reset clears init", csrRead, 16'h0004);
  endtask

  initial begin
    cyc(3);
    hardRst = 1'b0; softRst = 1'b0;
    cyc(1);
    t_reset();
    t_zero_write();
    t_start_alone();
    t_tdmd();
    t_stop();
    t_stop_wins();
    t_start_init();
    t_idon();
    t_events();
    t_stop_flags();
    t_resets();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule